// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block walks a chain of command blocks held in system memory and feeds the payload of each block into a downstream command sink, one 32-bit word per handshake. Every node begins with a header word. Its top byte gives the number of payload words that follow the header, and its low 24 bits point to the next node. The walk ends at the first pointer whose end-marker bit is set. While walking, the block adds up an estimated cycle cost for the whole chain. It also counts the nodes it visits, so that a chain which loops back on itself is cut off.

A host pulses `start` with a chain pointer. The walker then issues single-word reads on its memory port, one at a time. Reads are byte addresses of 32-bit words. It forwards payload words on a valid/ready sink port. When the walk ends it pulses `done`, and at that moment `cost` and `loop_flag` give the final result for the chain. The meaning of the command words is left to the sink.

Top module: `dma_chain_walker`

## Requirements
- R1: On an accepted `start`, the pointer is `start_addr` with bits 31:24 cleared. If bit 23 of that pointer is set, the walk ends with no memory read, `done` pulses and `cost` is 0.
- R2: A header word is decoded as payload length = bits 31:24 and next-node pointer = bits 23:0. The walk ends when the next pointer has bit 23 set.
- R3: Every memory read address is the current 24-bit pointer cut to its low 21 bits, with bits 1:0 cleared.
- R4: The payload words of a node are read from the header address + 4, + 8, and so on, in increasing order. The address wraps inside the 21-bit space. They appear on the sink in that same order.
- R5: A node of length 0 forwards no payload word and causes no payload read. The next header is read straight after it.
- R6: Each node adds 10 to `cost`, and a node with a nonzero length L adds a further 5 + L. `done` is a one-cycle pulse, and `cost` holds its final value from the `done` cycle until the next accepted `start`.
- R7: While `sink_valid` is high and `sink_ready` is low, `sink_valid` and `sink_data` hold. Each word is delivered exactly once.
- R8: If the walker has visited 8192 (LOOP_LIMIT) nodes and the next pointer is not an end marker, it stops, raises `loop_flag` and pulses `done`. `loop_flag` clears at the next accepted `start`.
- R9: A `start` pulse while `busy` is high is ignored: the running walk and its result are unchanged.
- R10: `mem_req` is a one-cycle pulse, asserted only while `busy` is high. No new request is issued until the previous one has returned through `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| start_addr | input | 32 | Pointer to the first node |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| loop_flag | output | 1 | Last walk was cut off by the node limit |
| cost | output | 32 | Accumulated cycle estimate |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 21 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| sink_valid | output | 1 | Payload word available |
| sink_data | output | 32 | Payload word |
| sink_ready | input | 1 | Sink accepts the word |

## Verification
The walker is driven with several chain shapes:
- A three-node chain that mixes zero and nonzero lengths. It separates the cost formula for empty nodes from the one for loaded nodes, and it checks that an empty node issues no payload read.
- A pointer with stray high bits set. It shows that both the 24-bit mask on the start pointer and the 21-bit mask on memory addresses are applied.
- A node placed at the top of memory, so that its payload wraps to address 0.
- A long node under random sink backpressure, which shows that words are neither dropped nor repeated.
- A node that points to itself. It runs into the loop limit, and the walk after it must clear the flag.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;

  localparam int PTR_W        = 24;
  localparam int MEM_AW       = 21;
  localparam int LEN_W        = 8;
  localparam int END_BIT      = 23;
  localparam int NODE_COST    = 10;
  localparam int LOADED_EXTRA = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HDR,
    ST_PL_REQ,
    ST_PL_WAIT,
    ST_PL_SEND
  } walk_state_t;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [PTR_W-1:0] next;
  } node_hdr_t;

  function automatic node_hdr_t split_header(input logic [31:0] w);
    return node_hdr_t'(w);
  endfunction

  function automatic logic [MEM_AW-1:0] ptr_to_mem(input logic [PTR_W-1:0] p);
    return {p[MEM_AW-1:2], 2'b00};
  endfunction

  function automatic logic [31:0] node_cost(input logic [LEN_W-1:0] len);
    logic [31:0] c;
    c = 32'(NODE_COST);
    if (len != '0) c = c + 32'(LOADED_EXTRA) + 32'(len);
    return c;
  endfunction

endpackage

// File: rtl/chain_cost_acc.sv
module chain_cost_acc
  import chain_walker_pkg::*;
#(
  parameter int COST_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic [LEN_W-1:0] len,
  output logic [COST_W-1:0] cost
);
  logic [31:0] step_cost;
  assign step_cost = node_cost(len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cost <= '0;
    else if (clear)  cost <= '0;
    else if (add_en) cost <= cost + COST_W'(step_cost);
  end
endmodule

// File: rtl/chain_node_guard.sv
module chain_node_guard #(
  parameter int LOOP_LIMIT = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic at_limit
);
  localparam int CNT_W = $clog2(LOOP_LIMIT + 1);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count <= '0;
    else if (clear)             count <= '0;
    else if (inc && !at_limit)  count <= count + 1'b1;
  end

  assign at_limit = (count == CNT_W'(LOOP_LIMIT));
endmodule

// File: rtl/chain_payload_ctr.sv
module chain_payload_ctr
  import chain_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PTR_W-1:0]  base_ptr,
  input  logic [LEN_W-1:0]  len,
  input  logic              step,
  output logic [MEM_AW-1:0] cur_addr,
  output logic              last
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= ptr_to_mem(base_ptr) + MEM_AW'(4);
      remain   <= len;
    end else if (step) begin
      cur_addr <= cur_addr + MEM_AW'(4);
      remain   <= remain - 1'b1;
    end
  end

  assign last = (remain == LEN_W'(1));
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
  import chain_walker_pkg::*;
#(
  parameter int COST_W     = 32,
  parameter int LOOP_LIMIT = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_addr,
  output logic              busy,
  output logic              done,
  output logic              loop_flag,
  output logic [COST_W-1:0] cost,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              sink_valid,
  output logic [31:0]       sink_data,
  input  logic              sink_ready
);
  walk_state_t       state;
  logic [PTR_W-1:0]  cur_ptr;
  logic [PTR_W-1:0]  next_ptr;
  logic [31:0]       word_q;
  node_hdr_t         hdr;
  logic [MEM_AW-1:0] pl_addr;
  logic              pl_last;
  logic              at_limit;

  // named events, also watched by the checker
  logic start_accept, hdr_accept, word_fire, at_end, walk_finish, loop_stop;

  assign hdr          = split_header(mem_rdata);
  assign start_accept = (state == ST_IDLE) && start;
  assign hdr_accept   = (state == ST_HDR) && mem_rvalid;
  assign word_fire    = (state == ST_PL_SEND) && sink_ready;
  assign at_end       = cur_ptr[END_BIT];
  assign walk_finish  = (state == ST_CHECK) && (at_end || at_limit);
  assign loop_stop    = walk_finish && !at_end;

  chain_cost_acc #(.COST_W(COST_W)) u_cost (
    .clk(clk), .rst_n(rst_n), .clear(start_accept),
    .add_en(hdr_accept), .len(hdr.len), .cost(cost)
  );

  chain_node_guard #(.LOOP_LIMIT(LOOP_LIMIT)) u_guard (
    .clk(clk), .rst_n(rst_n), .clear(start_accept),
    .inc(hdr_accept), .at_limit(at_limit)
  );

  chain_payload_ctr u_pl (
    .clk(clk), .rst_n(rst_n), .load(hdr_accept), .base_ptr(cur_ptr),
    .len(hdr.len), .step(word_fire), .cur_addr(pl_addr), .last(pl_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_ptr   <= '0;
      next_ptr  <= '0;
      word_q    <= '0;
      done      <= 1'b0;
      loop_flag <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          cur_ptr   <= start_addr[PTR_W-1:0];
          loop_flag <= 1'b0;
          state     <= ST_CHECK;
        end
        ST_CHECK: begin
          if (walk_finish) begin
            done      <= 1'b1;
            loop_flag <= loop_stop;
            state     <= ST_IDLE;
          end else begin
            state <= ST_HDR;
          end
        end
        ST_HDR: if (mem_rvalid) begin
          next_ptr <= hdr.next;
          if (hdr.len == '0) begin
            cur_ptr <= hdr.next;
            state   <= ST_CHECK;
          end else begin
            state <= ST_PL_REQ;
          end
        end
        ST_PL_REQ: state <= ST_PL_WAIT;
        ST_PL_WAIT: if (mem_rvalid) begin
          word_q <= mem_rdata;
          state  <= ST_PL_SEND;
        end
        ST_PL_SEND: if (sink_ready) begin
          if (pl_last) begin
            cur_ptr <= next_ptr;
            state   <= ST_CHECK;
          end else begin
            state <= ST_PL_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign mem_req    = ((state == ST_CHECK) && !walk_finish) || (state == ST_PL_REQ);
  assign mem_addr   = (state == ST_PL_REQ) ? pl_addr : ptr_to_mem(cur_ptr);
  assign sink_valid = (state == ST_PL_SEND);
  assign sink_data  = word_q;
endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk #(
  parameter int COST_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              loop_flag,
  input logic [COST_W-1:0] cost,
  input logic              mem_req,
  input logic              sink_valid,
  input logic              sink_ready,
  input logic [31:0]       sink_data,
  input logic              walk_finish
);
  p_sink_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sink_valid && !sink_ready |=> sink_valid && $stable(sink_data));

  p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_cost_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(cost));

  p_loop_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_flag) |-> done);

  p_finish_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_finish |=> done && !busy);
endmodule

bind dma_chain_walker chain_walker_chk #(.COST_W(COST_W)) u_chk (.*);

// File: tb/dma_chain_walker_tb.sv
module dma_chain_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        busy, done, loop_flag;
  logic [31:0] cost;
  logic        mem_req;
  logic [20:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        sink_valid;
  logic [31:0] sink_data;
  logic        sink_ready = 1'b1;

  bit [31:0]   mem [int];
  logic [31:0] exp_q [$];
  int n_cmp = 0, n_bad = 0, req_count = 0, cycles = 0;
  bit rand_ready = 0;
  bit finished = 0;

  dma_chain_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .loop_flag(loop_flag), .cost(cost),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .sink_valid(sink_valid), .sink_data(sink_data),
    .sink_ready(sink_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: one-cycle read latency, word-indexed by byte address
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem.exists(int'(mem_addr[20:2])) ? mem[int'(mem_addr[20:2])] : 32'h0;
    if (mem_req) req_count++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: drive ready, then compare delivered words
  always @(negedge clk) begin
    sink_ready = rand_ready ? ($urandom_range(0, 2) == 0) : 1'b1;
    #1;
    if (sink_valid && sink_ready) begin
      if (exp_q.size() == 0) check(0, "R4 unexpected word", sink_data, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(sink_data === e, "R4/R7 payload", sink_data, e);
      end
    end
  end

  function automatic logic [31:0] cost_of(input int len);
    return (len == 0) ? 32'd10 : 32'(15 + len);
  endfunction

  // driver: place a node and push its payload into the scoreboard
  task automatic put_node(input logic [20:0] a, input int len, input logic [23:0] nxt, input logic [31:0] seed);
    mem[int'(a[20:2])] = {8'(len), nxt};
    for (int i = 0; i < len; i++) begin
      logic [20:0] pa;
      pa = a + 21'(4 * (i + 1));
      mem[int'(pa[20:2])] = seed + 32'(i * 7);
      exp_q.push_back(seed + 32'(i * 7));
    end
  endtask

  task automatic run_walk(input logic [31:0] sa, input logic [31:0] exp_cost, input bit exp_loop,
                          input int exp_reqs, input string tag, input bit poke = 0);
    int t, r0;
    r0 = req_count;
    @(negedge clk); start = 1'b1; start_addr = sa;
    @(negedge clk); start = 1'b0; start_addr = 32'h00800123;
    t = 0;
    while (!done && t < 60000) begin
      if (poke && t == 3) start = 1'b1;
      @(negedge clk); start = 1'b0; t++;
    end
    check(done === 1'b1, {tag, " done seen"}, 32'(done), 32'h1);
    check(cost === exp_cost, {tag, " cost"}, cost, exp_cost);
    check(loop_flag === exp_loop, {tag, " loop_flag"}, 32'(loop_flag), 32'(exp_loop));
    check(req_count - r0 == exp_reqs, {tag, " read count"}, 32'(req_count - r0), 32'(exp_reqs));
    @(negedge clk);
    check(done === 1'b0 && cost === exp_cost, "R6 done pulse, cost held", 32'(done), 32'h0);
    check(exp_q.size() == 0, {tag, " all words delivered"}, 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    forever begin
      @(negedge clk); cycles++;
      if (cycles > 190000 && !finished) begin
        check(0, "watchdog", 32'(cycles), 32'd190000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_req && !sink_valid && !loop_flag, "R10 reset idle", 32'(busy), 32'h0);

    // R1: end marker in the start pointer, high byte ignored
    run_walk(32'hFF800000, 32'd0, 1'b0, 0, "R1");

    // R2, R5, R6: mixed lengths, zero-length node in the middle
    put_node(21'h000100, 4, 24'h002000, 32'hA0000000);
    put_node(21'h002000, 0, 24'h003000, 32'h0);
    put_node(21'h003000, 2, 24'hFFFFFF, 32'hB0000000);
    run_walk(32'h00000100, cost_of(4) + cost_of(0) + cost_of(2), 1'b0, 9, "R2/R5/R6");

    // R3: stray bits above 23 and bits 22:21 in pointers
    put_node(21'h000040, 1, 24'h7FFF80, 32'hC0000000);
    put_node(21'h1FFF80, 2, 24'h800000, 32'hC1000000);
    run_walk(32'hAB600040, cost_of(1) + cost_of(2), 1'b0, 5, "R3");

    // R4: payload wraps through the top of the 21-bit space, R7 backpressure
    rand_ready = 1;
    put_node(21'h1FFFF8, 3, 24'h800000, 32'hD0000000);
    run_walk(32'h001FFFF8, cost_of(3), 1'b0, 4, "R4/R7");

    // R7: long node under random backpressure
    put_node(21'h004000, 20, 24'h900000, 32'hE0000000);
    run_walk(32'h00004000, cost_of(20), 1'b0, 21, "R7");
    rand_ready = 0;

    // R9: a second start during the walk is ignored
    put_node(21'h006000, 5, 24'h006100, 32'hF0000000);
    put_node(21'h006100, 1, 24'h800000, 32'hF1000000);
    run_walk(32'h00006000, cost_of(5) + cost_of(1), 1'b0, 8, "R9", 1'b1);

    // R8: self-referencing node hits the node limit
    put_node(21'h005000, 0, 24'h005000, 32'h0);
    run_walk(32'h00005000, 32'd81920, 1'b1, 8192, "R8 loop");

    // R8: next walk clears loop_flag
    put_node(21'h007000, 1, 24'h800000, 32'h12345678);
    run_walk(32'h00007000, cost_of(1), 1'b0, 2, "R8 clear");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule